// File: doc/BRIEF.md
# GPIO Output Latch with Atomic Bit Updates

This block is the output stage of a 32-pin general-purpose I/O port. It keeps one output latch bit per pin and one direction bit per pin, both reachable over a small single-cycle register bus. Software can overwrite the whole latch at once, or change chosen bits through three write-only alias registers that set, clear or invert exactly the bits written as 1. Because each alias write only names the bits to change, no read-modify-write sequence is needed. This keeps updates safe when several agents share one port.

Each pin drives its latched value only when its direction bit is 1. A pin whose direction bit is 0 is left undriven, but its latch still follows every alias write. Software can therefore preload a level before it turns the pin into an output.

Top module: `gpio_out_port`

## Requirements
- R1: While reset is asserted and right after it, the latch and direction bits are all 0, so `pin_oe` and `pin_out` are all 0 and both readable registers return 0.
- R2: A write to byte offset 0x00 loads the latch with `bus_wdata`, and a read of 0x00 returns the latch.
- R3: A write to offset 0x04 loads the direction bits, and a read of 0x04 returns them. A direction bit of 1 means output.
- R4: A write to offset 0x08 sets to 1 every latch bit n for which `bus_wdata[n]` is 1. Bits written as 0 keep their value.
- R5: A write to offset 0x0C clears to 0 every latch bit n for which `bus_wdata[n]` is 1. Bits written as 0 keep their value.
- R6: A write to offset 0x10 inverts every latch bit n for which `bus_wdata[n]` is 1. Bits written as 0 keep their value.
- R7: Reads of offsets 0x08, 0x0C and 0x10 always return 0.
- R8: Set, clear and toggle writes change latch bits whose direction bit is 0, the same as bits whose direction bit is 1.
- R9: `pin_oe` equals the direction bits. `pin_out[n]` equals latch bit n when direction bit n is 1 and is 0 otherwise.
- R10: Each write acts on the latch value left by the previous cycle, so toggles on consecutive cycles alternate a bit, and a set followed at once by a clear leaves it 0.
- R11: Writes to any other address, including unaligned ones such as 0x02 or 0x14, change nothing, and reads of those addresses return 0.
- R12: A write takes effect at the rising clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_out | output | 32 | Per-pin drive value |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
The latch is driven with whole-word loads, then with set, clear and toggle masks that overlap bits already at 1 and at 0. This separates a true bitwise OR, AND-NOT or XOR from a plain overwrite. All-zero masks and writes to unmapped or unaligned addresses show whether a no-effect write really leaves both registers untouched. Alias writes made while every direction bit is 0 show that the latch updates independently of the pin gating. Consecutive toggle writes, and a set followed at once by a clear, show whether each write builds on the previous cycle's latch or on a stale copy.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  // register slot indices; byte offset of slot i is 4*i
  localparam int REG_DATA = 0;
  localparam int REG_DIR  = 1;
  localparam int REG_SET  = 2;
  localparam int REG_CLR  = 3;
  localparam int REG_TGL  = 4;
  localparam int NUM_REGS = 5;
  localparam int SLOT_BYTES = 4;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_out_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr,
  input  logic                wr,
  output logic [NUM_REGS-1:0] hit,
  output logic [NUM_REGS-1:0] wr_hit
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_slot
      localparam logic [AW-1:0] SLOT_ADDR = AW'(gi * SLOT_BYTES);
      assign hit[gi]    = (addr == SLOT_ADDR);
      assign wr_hit[gi] = hit[gi] & wr;
    end
  endgenerate

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R10
endmodule

// File: rtl/gpio_latch_bank.sv
module gpio_latch_bank
  import gpio_out_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] wr_hit,
  input  logic [NPINS-1:0]    wdata,
  output logic [NPINS-1:0]    latch_q,
  output logic [NPINS-1:0]    dir_q
);
  logic [NPINS-1:0] latch_d;
  logic [NPINS-1:0] dir_d;
  logic             latch_en;
  logic             dir_en;

  assign latch_en = wr_hit[REG_DATA] | wr_hit[REG_SET] |
                    wr_hit[REG_CLR]  | wr_hit[REG_TGL];
  assign dir_en   = wr_hit[REG_DIR];

  always_comb begin
    latch_d = latch_q;
    if (wr_hit[REG_DATA]) latch_d = wdata;
    if (wr_hit[REG_SET])  latch_d = latch_q | wdata;
    if (wr_hit[REG_CLR])  latch_d = latch_q & ~wdata;
    if (wr_hit[REG_TGL])  latch_d = latch_q ^ wdata;
    dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[REG_DATA] |=> (latch_q == $past(wdata))); // R2
  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[REG_DIR] |=> (dir_q == $past(wdata))); // R3
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[REG_SET] |=> (((latch_q & $past(wdata)) == $past(wdata)) &&
                         ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))))); // R4
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[REG_CLR] |=> (((latch_q & $past(wdata)) == '0) &&
                         ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata))))); // R5
  AST_TGL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[REG_TGL] |=> (latch_q == ($past(latch_q) ^ $past(wdata)))); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit[REG_DATA] | wr_hit[REG_SET] | wr_hit[REG_CLR] | wr_hit[REG_TGL])
      |=> $stable(latch_q)); // R11
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit[REG_DIR] |=> $stable(dir_q)); // R11
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback #(
  parameter int NPINS = 32
) (
  input  logic             sel_data,
  input  logic             sel_dir,
  input  logic [NPINS-1:0] latch_q,
  input  logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (sel_data) rdata = latch_q;
    if (sel_dir)  rdata = dir_q;
  end
endmodule

// File: rtl/gpio_out_port.sv
module gpio_out_port
  import gpio_out_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  logic                rst_n_int;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NPINS-1:0]    latch_q;
  logic [NPINS-1:0]    dir_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_reg_decode #(.AW(AW)) u_dec (
    .clk   (clk),
    .rst_n (rst_n_int),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .hit   (hit),
    .wr_hit(wr_hit)
  );

  gpio_latch_bank #(.NPINS(NPINS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_hit (wr_hit),
    .wdata  (bus_wdata),
    .latch_q(latch_q),
    .dir_q  (dir_q)
  );

  gpio_readback #(.NPINS(NPINS)) u_rd (
    .sel_data(hit[REG_DATA]),
    .sel_dir (hit[REG_DIR]),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .rdata   (bus_rdata)
  );

  // direction gating of the pad drive
  assign pin_oe  = dir_q;
  assign pin_out = latch_q & dir_q;

  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((bus_addr == AW'(8)) || (bus_addr == AW'(12)) || (bus_addr == AW'(16)))
      |-> (bus_rdata == '0)); // R7
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((pin_out & ~pin_oe) == '0)); // R9
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n_int)
    (bus_wr && bus_addr == AW'(4)) |=> (pin_oe == $past(bus_wdata))); // R3
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n_int |-> (pin_oe == '0 && pin_out == '0)); // R1
endmodule

// File: tb/gpio_out_port_test.sv
`timescale 1ns/1ps
module gpio_out_port_test;
  localparam int NPINS = 32;
  localparam int AW    = 5;

  typedef struct packed {
    logic [AW-1:0]    addr;
    logic [NPINS-1:0] wdata;
    logic [NPINS-1:0] exp_lat;
    logic [NPINS-1:0] exp_dir;
    logic [3:0]       req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{5'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, 32'h0000_0000, 4'd2},  // R2 load
    '{5'h04, 32'hFFFF_0000, 32'hA5A5_0F0F, 32'hFFFF_0000, 4'd3},  // R3 direction
    '{5'h08, 32'h0000_00F0, 32'hA5A5_0FFF, 32'hFFFF_0000, 4'd4},  // R4 set
    '{5'h0C, 32'h0F00_000F, 32'hA0A5_0FF0, 32'hFFFF_0000, 4'd5},  // R5 clear
    '{5'h10, 32'hFFFF_FFFF, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd6},  // R6 toggle
    '{5'h08, 32'h0000_0000, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd4},  // R4 zero mask
    '{5'h0C, 32'h0000_0000, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd5},  // R5 zero mask
    '{5'h10, 32'h0000_0000, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd6},  // R6 zero mask
    '{5'h14, 32'hFFFF_FFFF, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd11}, // R11 unmapped
    '{5'h02, 32'h0000_0000, 32'h5F5A_F00F, 32'hFFFF_0000, 4'd11}, // R11 unaligned
    '{5'h04, 32'h0000_0000, 32'h5F5A_F00F, 32'h0000_0000, 4'd3},  // R3 all inputs
    '{5'h08, 32'h0000_FFFF, 32'h5F5A_FFFF, 32'h0000_0000, 4'd8},  // R8 set on inputs
    '{5'h10, 32'hFFFF_0000, 32'hA0A5_FFFF, 32'h0000_0000, 4'd8},  // R8 toggle on inputs
    '{5'h04, 32'h00FF_00FF, 32'hA0A5_FFFF, 32'h00FF_00FF, 4'd9}   // R9 gating
  };

  logic             clk;
  logic             rst_n;
  logic [AW-1:0]    bus_addr;
  logic             bus_wr;
  logic [NPINS-1:0] bus_wdata;
  logic [NPINS-1:0] bus_rdata;
  logic [NPINS-1:0] pin_out;
  logic [NPINS-1:0] pin_oe;

  int errors = 0;
  int checks = 0;

  gpio_out_port #(.NPINS(NPINS), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [NPINS-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_at(input logic [AW-1:0] a, output logic [NPINS-1:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NPINS-1:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe in reset", pin_oe, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_at(5'h00, r); chk("R1 latch after reset", r, '0);
    read_at(5'h04, r); chk("R1 dir after reset", r, '0);
    chk("R1 pin_out after reset", pin_out, '0);
    chk("R1 pin_oe after reset", pin_oe, '0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      do_write(VECS[i].addr, VECS[i].wdata);
      read_at(5'h00, r); chk({tag, " latch"}, r, VECS[i].exp_lat);
      read_at(5'h04, r); chk({tag, " dir"}, r, VECS[i].exp_dir);
      chk({tag, " pin_oe"}, pin_oe, VECS[i].exp_dir);
      chk({tag, " pin_out"}, pin_out, VECS[i].exp_lat & VECS[i].exp_dir);
    end

    // R7 alias registers read as zero while latch is nonzero
    read_at(5'h08, r); chk("R7 set reads zero", r, '0);
    read_at(5'h0C, r); chk("R7 clear reads zero", r, '0);
    read_at(5'h10, r); chk("R7 toggle reads zero", r, '0);
    // R11 unmapped reads
    read_at(5'h14, r); chk("R11 unmapped reads zero", r, '0);
    read_at(5'h01, r); chk("R11 unaligned reads zero", r, '0);

    // R10 back-to-back toggles of bit 0
    do_write(5'h04, 32'hFFFF_FFFF);
    do_write(5'h00, 32'h0000_0000);
    @(negedge clk);
    bus_addr = 5'h10; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(negedge clk); chk("R10 toggle 1", pin_out, 32'h1);
    @(negedge clk); chk("R10 toggle 2", pin_out, 32'h0);
    @(negedge clk); chk("R10 toggle 3", pin_out, 32'h1);
    // R10 set then clear on consecutive cycles
    bus_addr = 5'h08; bus_wdata = 32'h2;
    @(negedge clk); chk("R10 set then", pin_out, 32'h3);
    bus_addr = 5'h0C;
    @(negedge clk); chk("R10 clear after set", pin_out, 32'h1);
    bus_wr = 1'b0;

    // R12 write not visible before the edge, visible after
    @(negedge clk);
    bus_addr = 5'h00; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1;
    #0.5; chk("R12 before edge", bus_rdata, 32'h1);
    @(negedge clk); bus_wr = 1'b0;
    #0.5; chk("R12 after edge", bus_rdata, 32'hDEAD_BEEF);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk("R1 async pin_oe", pin_oe, '0);
    chk("R1 async pin_out", pin_out, '0);
    read_at(5'h00, r); chk("R1 async latch", r, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_at(5'h04, r); chk("R1 dir after second reset", r, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule